// File: doc/BRIEF.md
# Reset Qualifier with Emulation-Mode Entry

This block sits between the raw reset pin of a microcontroller and the rest of the chip. It first synchronizes the reset pin, the address-latch strobe pin (ALE), the active-low program-store strobe pin (PSEN_n) and the external-access strap. It then issues an internal reset only after the reset pin has been seen high for a full two-machine-cycle window. A pin that drops before the window completes restarts the count from zero, so glitches and short pulses never reset the chip.

The same block recognises a pin-level handshake that places the chip in a test state. In this state an external tester drives the board. The state is armed when ALE is held low and PSEN_n is high while the internal reset is active. It is entered when ALE is still low at the moment the internal reset is released. While the test state is active, the block tells the pad ring to float the low address/data port and to hold every other pin, ALE and PSEN_n included, with weak pull-ups only. The clock is not touched. A later reset whose release sees ALE high returns the chip to normal operation.

The block also holds the external-access strap. When any code-protection lock is programmed, the strap value is taken during reset and frozen until the next reset. Otherwise the strap simply follows the pin.

Top module: `rstq_top`

## Requirements
- R1: With the defaults (12 clocks per machine cycle, 2 machine cycles, HOLD = 24), `int_rst` rises on the 26th rising clock edge, counting the first edge that samples `rst_pin` high, provided the pin stays high. It is still low after the 25th edge.
- R2: A `rst_pin` high pulse covering only HOLD-1 (23) sampling edges never raises `int_rst`.
- R3: If `rst_pin` drops before the count completes, the count restarts from zero. Two 20-edge pulses separated by one low sample never raise `int_rst`.
- R4: Once `int_rst` is high, it stays high after the first two rising edges that follow the first low sample of `rst_pin`, and falls on the third. After `arst_n` releases, `int_rst`, `emu_mode` and `ea_latched` are 0.
- R5: If ALE is low and PSEN_n high (value 1) at some edge while `int_rst` is high, and ALE is still low when `int_rst` is released, then `emu_mode` becomes 1.
- R6: If PSEN_n stays low (0) for the whole reset, ALE low at release does not enter emulation mode (`emu_mode` = 0).
- R7: A release with ALE high leaves `emu_mode` at 0. This holds even when the mode was armed earlier in the same reset, and it also clears an active emulation mode.
- R8: Outside a reset release, `emu_mode` does not change. Toggling ALE/PSEN_n, or a reset pulse shorter than HOLD, leaves it unchanged.
- R9: With `lock_prog` = 1, `ea_latched` takes the strap value during reset and then holds it, whatever later changes the strap pin makes.
- R10: With `lock_prog` = 0, `ea_latched` follows `ea_strap`. A change sampled at one edge appears after the third edge.
- R11: `float_low_port` and `weak_pull_high` are both 1 exactly when `emu_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-up clear from the supply monitor, active low |
| rst_pin | input | 1 | Raw reset pin, active high |
| ale_pin | input | 1 | Sampled level of the address-latch strobe pin |
| psen_n_pin | input | 1 | Sampled level of the program-store strobe pin, active low |
| ea_strap | input | 1 | External-access strap pin level |
| lock_prog | input | 1 | 1 when any code-protection lock is programmed |
| int_rst | output | 1 | Qualified internal reset, active high |
| emu_mode | output | 1 | Emulation (test) mode is active |
| float_low_port | output | 1 | Directive: float the low address/data port |
| weak_pull_high | output | 1 | Directive: weak pull-ups only on other ports, ALE and PSEN_n |
| ea_latched | output | 1 | External-access bit seen by the core |

## Verification
A stuck or miscounted qualification counter shows on `int_rst` within HOLD+2 edges as an early, late or missing reset. A counter that fails to clear on a low sample only shows later, as a reset raised by two short pulses. A wrong arm flag stays hidden until the next reset release, and then shows at once on `emu_mode` and both pad directives. A strap latch that fails to freeze shows within three edges of the first strap change after reset. The reference model compares every output on every cycle, so each of these shows up in the cycle it first differs.

// File: rtl/rstq_pkg.sv
package rstq_pkg;

  typedef struct packed {
    logic float_low;
    logic weak_pull;
  } pad_dir_t;

  function automatic int hold_clocks(input int clks_per_mcycle, input int mcycles);
    return clks_per_mcycle * mcycles;
  endfunction

  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic pad_dir_t pad_for(input logic emu);
    pad_dir_t d;
    d.float_low = emu;
    d.weak_pull = emu;
    return d;
  endfunction

endpackage

// File: rtl/rstq_sync.sv
module rstq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage[0] <= RST_VAL;
    else         stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stage[i] <= RST_VAL;
      else         stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rstq_qualify.sv
module rstq_qualify #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_s,
  output logic int_rst,
  output logic rel_evt
);
  localparam int CW = rstq_pkg::cnt_bits(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          full;

  assign full    = (cnt == LAST);
  assign rel_evt = int_rst && !rst_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt <= '0;
    else if (!rst_s) cnt <= '0;
    else if (!full)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) int_rst <= 1'b0;
    else         int_rst <= rst_s && (int_rst || full);
  end

  a_r1_rise_after_full_window: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(int_rst) |-> $past(cnt) == LAST);
  a_r2_no_early_reset: assert property (@(posedge clk) disable iff (!arst_n)
    (!int_rst && cnt != LAST) |=> !int_rst);
  a_r3_count_restarts: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_s |=> cnt == '0);
  a_r4_release_follows_pin: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_s |=> !int_rst);
endmodule

// File: rtl/rstq_emu.sv
module rstq_emu (
  input  logic clk,
  input  logic arst_n,
  input  logic int_rst,
  input  logic rel_evt,
  input  logic ale_s,
  input  logic psen_n_s,
  output logic emu_mode
);
  logic armed;
  logic arm_now;
  logic armed_eff;

  assign arm_now   = int_rst && !ale_s && psen_n_s;
  assign armed_eff = armed || arm_now;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      armed <= 1'b0;
    else if (rel_evt) armed <= 1'b0;
    else if (int_rst) armed <= armed_eff;
    else              armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      emu_mode <= 1'b0;
    else if (rel_evt) emu_mode <= armed_eff && !ale_s;
  end

  a_r5_enter_on_handshake: assert property (@(posedge clk) disable iff (!arst_n)
    (rel_evt && armed_eff && !ale_s) |=> emu_mode);
  a_r6_no_entry_unarmed: assert property (@(posedge clk) disable iff (!arst_n)
    (rel_evt && !armed_eff) |=> !emu_mode);
  a_r7_leave_on_normal_release: assert property (@(posedge clk) disable iff (!arst_n)
    (rel_evt && ale_s) |=> !emu_mode);
  a_r8_hold_between_releases: assert property (@(posedge clk) disable iff (!arst_n)
    !rel_evt |=> $stable(emu_mode));
endmodule

// File: rtl/rstq_ea.sv
module rstq_ea (
  input  logic clk,
  input  logic arst_n,
  input  logic int_rst,
  input  logic lock_prog,
  input  logic ea_s,
  output logic ea_latched
);
  logic take;

  assign take = !lock_prog || int_rst;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   ea_latched <= 1'b0;
    else if (take) ea_latched <= ea_s;
  end

  a_r9_frozen_when_locked: assert property (@(posedge clk) disable iff (!arst_n)
    (lock_prog && !int_rst) |=> $stable(ea_latched));
  a_r10_follows_when_open: assert property (@(posedge clk) disable iff (!arst_n)
    !lock_prog |=> ea_latched == $past(ea_s));
endmodule

// File: rtl/rstq_top.sv
module rstq_top #(
  parameter int CLKS_PER_MCYCLE = 12,
  parameter int MCYCLES         = 2,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  input  logic ale_pin,
  input  logic psen_n_pin,
  input  logic ea_strap,
  input  logic lock_prog,
  output logic int_rst,
  output logic emu_mode,
  output logic float_low_port,
  output logic weak_pull_high,
  output logic ea_latched
);
  import rstq_pkg::*;

  localparam int HOLD = hold_clocks(CLKS_PER_MCYCLE, MCYCLES);
  // bit order: {ea, psen_n, ale, rst}; strobes idle high
  localparam logic [3:0] SYNC_RST = 4'b0110;

  logic [3:0] raw_v;
  logic [3:0] syn_v;
  logic       rst_s, ale_s, psen_n_s, ea_s;
  logic       rel_evt;
  pad_dir_t   pads;

  assign raw_v = {ea_strap, psen_n_pin, ale_pin, rst_pin};

  rstq_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(raw_v), .q(syn_v)
  );

  assign rst_s    = syn_v[0];
  assign ale_s    = syn_v[1];
  assign psen_n_s = syn_v[2];
  assign ea_s     = syn_v[3];

  rstq_qualify #(.HOLD(HOLD)) u_qual (
    .clk(clk), .arst_n(arst_n), .rst_s(rst_s), .int_rst(int_rst), .rel_evt(rel_evt)
  );

  rstq_emu u_emu (
    .clk(clk), .arst_n(arst_n), .int_rst(int_rst), .rel_evt(rel_evt),
    .ale_s(ale_s), .psen_n_s(psen_n_s), .emu_mode(emu_mode)
  );

  rstq_ea u_ea (
    .clk(clk), .arst_n(arst_n), .int_rst(int_rst), .lock_prog(lock_prog),
    .ea_s(ea_s), .ea_latched(ea_latched)
  );

  assign pads           = pad_for(emu_mode);
  assign float_low_port = pads.float_low;
  assign weak_pull_high = pads.weak_pull;

  always_comb begin
    a_r11_pads_track_mode: assert (float_low_port == emu_mode && weak_pull_high == emu_mode);
  end
endmodule

// File: tb/sim_rstq_top.sv
module sim_rstq_top;
  localparam int HOLD = 24;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst_pin = 1'b0, ale_pin = 1'b1, psen_n_pin = 1'b1, ea_strap = 1'b0, lock_prog = 1'b0;
  logic int_rst, emu_mode, float_low_port, weak_pull_high, ea_latched;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit seen_rst = 0;

  always #2.5 clk = ~clk;

  rstq_top u0 (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .ale_pin(ale_pin),
    .psen_n_pin(psen_n_pin), .ea_strap(ea_strap), .lock_prog(lock_prog),
    .int_rst(int_rst), .emu_mode(emu_mode), .float_low_port(float_low_port),
    .weak_pull_high(weak_pull_high), .ea_latched(ea_latched)
  );

  // behavioural reference: pin history queues and a run length
  bit q_rst[$], q_ale[$], q_psn[$], q_ea[$];
  int run = 0;
  bit m_rst = 0, m_emu = 0, m_seen = 0, m_ea = 0;

  task automatic model_clear();
    q_rst = '{0, 0}; q_ale = '{1, 1}; q_psn = '{1, 1}; q_ea = '{0, 0};
    run = 0; m_rst = 0; m_emu = 0; m_seen = 0; m_ea = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!arst_n) model_clear();
    else begin
      bit rs, as, ps, es, old_rst;
      rs = q_rst[0]; as = q_ale[0]; ps = q_psn[0]; es = q_ea[0];
      old_rst = m_rst;
      run = rs ? ((run < HOLD) ? run + 1 : run) : 0;
      m_rst = (run >= HOLD);
      if (old_rst && !rs) begin
        m_emu = (m_seen || (!as && ps)) && !as;
        m_seen = 0;
      end else if (old_rst) m_seen = m_seen || (!as && ps);
      else m_seen = 0;
      if (!lock_prog || old_rst) m_ea = es;
      void'(q_rst.pop_front()); q_rst.push_back(rst_pin);
      void'(q_ale.pop_front()); q_ale.push_back(ale_pin);
      void'(q_psn.pop_front()); q_psn.push_back(psen_n_pin);
      void'(q_ea.pop_front());  q_ea.push_back(ea_strap);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (arst_n) begin
      if (int_rst) seen_rst = 1;
      chk(int_rst === m_rst, "R1 model int_rst", int_rst, m_rst);
      chk(emu_mode === m_emu, "R5 model emu_mode", emu_mode, m_emu);
      chk(float_low_port === m_emu, "R11 model float_low_port", float_low_port, m_emu);
      chk(weak_pull_high === m_emu, "R11 model weak_pull_high", weak_pull_high, m_emu);
      chk(ea_latched === m_ea, "R9 model ea_latched", ea_latched, m_ea);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic full_reset(input bit ale_at_rel);
    rst_pin = 1; cyc(30);
    ale_pin = ale_at_rel; cyc(3);
    rst_pin = 0; cyc(5);
  endtask

  initial begin
    cyc(3); arst_n = 1; cyc(1);
    chk(int_rst == 0 && emu_mode == 0 && ea_latched == 0, "R4 reset state",
        {int_rst, emu_mode, ea_latched}, 0);

    seen_rst = 0; rst_pin = 1; cyc(HOLD - 1); rst_pin = 0; cyc(6);
    chk(!seen_rst, "R2 short pulse ignored", seen_rst, 0);

    seen_rst = 0;
    rst_pin = 1; cyc(20); rst_pin = 0; cyc(1); rst_pin = 1; cyc(20); rst_pin = 0; cyc(6);
    chk(!seen_rst, "R3 count restarts", seen_rst, 0);

    rst_pin = 1; cyc(HOLD + 1);
    chk(int_rst == 0, "R1 not yet at edge 25", int_rst, 0);
    cyc(1);
    chk(int_rst == 1, "R1 asserted at edge 26", int_rst, 1);

    rst_pin = 0; cyc(2);
    chk(int_rst == 1, "R4 still high two edges after drop", int_rst, 1);
    cyc(1);
    chk(int_rst == 0, "R4 low on third edge", int_rst, 0);

    ale_pin = 0; psen_n_pin = 1; full_reset(0);
    chk(emu_mode == 1, "R5 emulation entered", emu_mode, 1);
    chk(float_low_port == 1 && weak_pull_high == 1, "R11 pads in emulation",
        {float_low_port, weak_pull_high}, 3);
    ale_pin = 1;

    for (int i = 0; i < 10; i++) begin ale_pin = i[0]; psen_n_pin = i[1]; cyc(1); end
    ale_pin = 1; psen_n_pin = 1; cyc(3);
    chk(emu_mode == 1, "R8 pin toggles ignored", emu_mode, 1);
    rst_pin = 1; cyc(10); rst_pin = 0; cyc(6);
    chk(emu_mode == 1, "R8 short reset keeps mode", emu_mode, 1);

    ale_pin = 0; full_reset(1);
    chk(emu_mode == 0, "R7 armed but ALE high at release", emu_mode, 0);

    ale_pin = 0; full_reset(0); ale_pin = 1;
    chk(emu_mode == 1, "R5 re-entered", emu_mode, 1);
    full_reset(1);
    chk(emu_mode == 0, "R7 normal reset leaves mode", emu_mode, 0);
    chk(float_low_port == 0 && weak_pull_high == 0, "R11 pads normal",
        {float_low_port, weak_pull_high}, 0);

    psen_n_pin = 0; ale_pin = 0; full_reset(0);
    chk(emu_mode == 0, "R6 PSEN_n low blocks entry", emu_mode, 0);
    ale_pin = 1; psen_n_pin = 1; cyc(3);

    lock_prog = 1; ea_strap = 1; full_reset(1);
    ea_strap = 0; cyc(10);
    chk(ea_latched == 1, "R9 strap frozen when locked", ea_latched, 1);
    full_reset(1); ea_strap = 1; cyc(10);
    chk(ea_latched == 0, "R9 new capture at reset", ea_latched, 0);

    lock_prog = 0; cyc(4); ea_strap = 0; cyc(4); ea_strap = 1; cyc(2);
    chk(ea_latched == 0, "R10 not yet after two edges", ea_latched, 0);
    cyc(1);
    chk(ea_latched == 1, "R10 follows after third edge", ea_latched, 1);

    cyc(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule